// File: doc/BRIEF.md
# Multi-Lane Serial Transfer Engine

This block is the shift engine of a serial flash/peripheral controller. It moves one transaction of up to 65535 bytes between a transmit byte stream, the data pins and a receive byte stream. A mode field chooses one, two or four data lanes for the whole transaction. The serial clock runs at half the rate of a `tick` input, which an outside timing block supplies. The engine drives the serial clock low, puts data out while the clock is low, and samples input on the rising clock edge.

Software, or a control register around the block, loads a byte count, a mode and a continue flag, then pulses `go`. For each byte the engine pulls one transmit byte through a valid/ready pair. It shifts the byte out over the selected lanes while it shifts received bits in, and it presents each received byte as a one-cycle pulse. When the last byte is done it sets a sticky completion flag, which is cleared by writing 1 to `done_clr`. A soft reset input abandons the transaction at any point.

Top module: `lane_shift_engine`

## Requirements
- R1: After `rst` the outputs are `cs_n`=1, `sclk`=0, `done_flag`=0, `tx_ready`=0, `rx_valid`=0 and `dout`=0.
- R2: Mode code 0 (single lane) sends one bit per rising `sclk` on `dout[0]`, most significant bit first, and samples `din[1]` on each rising `sclk`.
- R3: Mode code 1 (dual lane) sends two bits per rising `sclk` on `dout[1:0]`, with `dout[1]` the more significant bit and the top pair first. It samples `din[1:0]` the same way.
- R4: Mode code 2 (quad lane) sends a nibble per rising `sclk` on `dout[3:0]`, with `dout[3]` the most significant and the top nibble first. It samples `din[3:0]`. Mode codes 3 to 7 behave as code 0.
- R5: Each received byte appears on `rx_data` with `rx_valid` high for exactly one cycle, right after the falling `sclk` that ends the byte. The first sampled group forms the most significant bits.
- R6: When the next transmit byte is needed and `tx_valid` is low, `sclk` stays low and makes no edges until a byte is offered. Each `sclk` change happens only in a cycle with `tick` high.
- R7: A transaction of N bytes takes exactly N bytes from the transmit stream and makes exactly 8N/lanes rising `sclk` edges. `cs_n` is low from start to finish and goes high at the end unless continue was set.
- R8: `go` with a byte count of 0 sets `done_flag`, takes no byte and toggles neither `sclk` nor `cs_n`.
- R9: `done_flag` stays set until a cycle with `done_clr`=1 clears it. A completion in the same cycle as a clear wins, so the flag is set in the next cycle.
- R10: With `cfg_cont`=1 at `go`, `cs_n` stays low after completion. A later transaction started with `cfg_cont`=0 releases it at its end.
- R11: `soft_rst` returns the engine to idle in the next cycle with `cs_n`=1 and `sclk`=0. It drops the partial byte and the remaining count without setting `done_flag`. The next `go` then runs a normal transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Lane mode code, sampled at `go` |
| cfg_bytes | input | 16 | Byte count, sampled at `go` |
| cfg_cont | input | 1 | Keep select low after completion |
| go | input | 1 | Start pulse, accepted when idle |
| soft_rst | input | 1 | Abort and return to idle |
| tick | input | 1 | Serial half-period enable |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes the byte this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low device select |
| dout | output | 4 | Outgoing data lanes |
| din | input | 4 | Incoming data lanes |
| done_flag | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Write-1 clear of `done_flag` |

## Verification
Two functions can land in the same cycle: the final falling serial edge that sets the completion flag, and a software clear of that flag. The bench holds `done_clr` high for a whole transaction, so the completion pulse is bound to meet a clear. It then requires the flag to be seen high for a cycle and low once the clear goes on acting. The same sweep feeds inverted outgoing data back into `din` over every mode and several byte counts. This checks each sent group against its arithmetic pattern and each received byte against its complement.

// File: rtl/lse_pkg.sv
package lse_pkg;
  localparam int MAX_LANES = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } lse_state_t;

  typedef enum logic [1:0] {
    WID_1 = 2'd0,
    WID_2 = 2'd1,
    WID_4 = 2'd2
  } lse_width_t;
endpackage

// File: rtl/lse_byte_counter.sv
module lse_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || clr)   remain_q <= '0;
    else if (load)    remain_q <= load_val;
    else if (dec)     remain_q <= remain_q - CNT_W'(1);
  end

  assign last = (remain_q == CNT_W'(1));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> (remain_q != '0));
endmodule

// File: rtl/lse_shifter.sv
module lse_shifter import lse_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  lse_width_t        width,
  input  logic              rise,
  input  logic              fall,
  input  logic [LANES-1:0]  din,
  output logic [LANES-1:0]  dout,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] tx_sh, rx_sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load) tx_sh <= load_byte;
      else if (fall) begin
        case (width)
          WID_2:   tx_sh <= tx_sh << 2;
          WID_4:   tx_sh <= tx_sh << 4;
          default: tx_sh <= tx_sh << 1;
        endcase
      end
      if (rise) begin
        case (width)
          WID_2:   rx_sh <= {rx_sh[BYTE_W-3:0], din[1:0]};
          WID_4:   rx_sh <= {rx_sh[BYTE_W-5:0], din[3:0]};
          default: rx_sh <= {rx_sh[BYTE_W-2:0], din[1]};
        endcase
      end
    end
  end

  always_comb begin
    dout = '0;
    case (width)
      WID_2:   dout[1:0] = tx_sh[BYTE_W-1 -: 2];
      WID_4:   dout[3:0] = tx_sh[BYTE_W-1 -: 4];
      default: dout[0]   = tx_sh[BYTE_W-1];
    endcase
  end

  assign rx_byte = rx_sh;
endmodule

// File: rtl/lse_done_flag.sv
module lse_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/lane_shift_engine.sv
module lane_shift_engine import lse_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic [CNT_W-1:0]     cfg_bytes,
  input  logic                 cfg_cont,
  input  logic                 go,
  input  logic                 soft_rst,
  input  logic                 tick,
  input  logic [BYTE_W-1:0]    tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [BYTE_W-1:0]    rx_data,
  output logic                 rx_valid,
  output logic                 sclk,
  output logic                 cs_n,
  output logic [MAX_LANES-1:0] dout,
  input  logic [MAX_LANES-1:0] din,
  output logic                 done_flag,
  input  logic                 done_clr
);
  localparam int STEP_W = $clog2(BYTE_W);

  lse_state_t        state_q;
  lse_width_t        width_q, width_d;
  logic [STEP_W-1:0] step_q, last_idx;
  logic              sclk_q, cs_n_q, cont_q, rx_valid_q;
  logic [BYTE_W-1:0] rx_data_q, rx_byte;
  logic              rise_ev, fall_ev, byte_end, take, start_ev, zero_ev;
  logic              cnt_last, done_set;

  always_comb begin
    case (cfg_mode)
      MODE_W'(1): width_d = WID_2;
      MODE_W'(2): width_d = WID_4;
      default:    width_d = WID_1;
    endcase
    case (width_q)
      WID_2:   last_idx = STEP_W'(BYTE_W/2 - 1);
      WID_4:   last_idx = STEP_W'(BYTE_W/4 - 1);
      default: last_idx = STEP_W'(BYTE_W - 1);
    endcase
  end

  assign rise_ev  = (state_q == ST_SHIFT) && tick && !sclk_q && !soft_rst;
  assign fall_ev  = (state_q == ST_SHIFT) && tick &&  sclk_q && !soft_rst;
  assign byte_end = fall_ev && (step_q == last_idx);
  assign take     = (state_q == ST_LOAD) && tx_valid && !soft_rst;
  assign start_ev = (state_q == ST_IDLE) && go && !soft_rst && (cfg_bytes != '0);
  assign zero_ev  = (state_q == ST_IDLE) && go && !soft_rst && (cfg_bytes == '0);
  assign done_set = zero_ev || (byte_end && cnt_last);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state_q    <= ST_IDLE;
      width_q    <= WID_1;
      step_q     <= '0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      cont_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_ev) begin
          width_q <= width_d;
          cont_q  <= cfg_cont;
          cs_n_q  <= 1'b0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (take) begin
          step_q  <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          sclk_q <= !sclk_q;
          if (sclk_q) begin
            if (step_q == last_idx) begin
              rx_valid_q <= 1'b1;
              rx_data_q  <= rx_byte;
              if (cnt_last) begin
                state_q <= ST_IDLE;
                cs_n_q  <= !cont_q;
              end else begin
                state_q <= ST_LOAD;
              end
            end else begin
              step_q <= step_q + STEP_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lse_byte_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(soft_rst), .load(start_ev),
    .load_val(cfg_bytes), .dec(byte_end), .last(cnt_last)
  );

  lse_shifter #(.BYTE_W(BYTE_W), .LANES(MAX_LANES)) u_shift (
    .clk(clk), .rst(rst), .clr(soft_rst), .load(take), .load_byte(tx_data),
    .width(width_q), .rise(rise_ev), .fall(fall_ev && !byte_end),
    .din(din), .dout(dout), .rx_byte(rx_byte)
  );

  lse_done_flag u_done (
    .clk(clk), .rst(rst), .set(done_set), .clr(done_clr), .flag(done_flag)
  );

  assign tx_ready = (state_q == ST_LOAD) && !soft_rst;
  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
  assign sclk     = sclk_q;
  assign cs_n     = cs_n_q;

  // R6
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SHIFT) |-> !sclk_q);
  // R6
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !soft_rst) |=> $stable(sclk_q));
  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_q |=> !rx_valid_q);
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (state_q == ST_IDLE && cs_n_q && !sclk_q));
  // R7
  select_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> !cs_n_q);
endmodule

// File: tb/test_lane_shift_engine.sv
module test_lane_shift_engine;
  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] cfg_mode = '0;
  logic [15:0] cfg_bytes = '0;
  logic       cfg_cont = 1'b0, go = 1'b0, soft_rst = 1'b0, tick = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0, tx_ready, rx_valid, sclk, cs_n, done_flag;
  logic       done_clr = 1'b0;
  logic [7:0] rx_data;
  logic [3:0] dout, din;

  int checks = 0, errors = 0;
  logic [7:0] tx_mem [0:15];
  int  tx_n = 0, tx_idx = 0, rx_cnt = 0, mon_cnt = 0, mon_bits = 0;
  int  rises = 0, seen_done = 0, cur_lanes = 1;
  bit  hs_prev = 0, stall = 0, sclk_prev = 0;
  logic [7:0] mon_sh = '0;

  always #4 clk = ~clk;

  lane_shift_engine i_lane_shift_engine (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_bytes(cfg_bytes),
    .cfg_cont(cfg_cont), .go(go), .soft_rst(soft_rst), .tick(tick),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n),
    .dout(dout), .din(din), .done_flag(done_flag), .done_clr(done_clr)
  );

  // inverted loopback: single lane returns on din[1]
  assign din = (cur_lanes == 1) ? {2'b00, ~dout[0], 1'b0} : ~dout;

  function automatic int lanes_of(int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // tick toggles so that sclk runs at a quarter of clk
  always @(negedge clk) tick <= ~tick;

  // transmit source and monitors
  always @(negedge clk) begin
    if (hs_prev) tx_idx++;
    tx_valid = !stall && (tx_idx < tx_n);
    tx_data  = tx_mem[tx_idx % 16];
    hs_prev  = tx_valid && tx_ready;
    if (done_flag) seen_done++;
    if (sclk && !sclk_prev) begin
      rises++;
      case (cur_lanes)
        2:       mon_sh = {mon_sh[5:0], dout[1:0]};
        4:       mon_sh = {mon_sh[3:0], dout[3:0]};
        default: mon_sh = {mon_sh[6:0], dout[0]};
      endcase
      mon_bits += cur_lanes;
      if (mon_bits == 8) begin
        chk(mon_sh == tx_mem[mon_cnt % 16], "R2/R3/R4", "sent byte",
            mon_sh, tx_mem[mon_cnt % 16]);
        mon_cnt++;
        mon_bits = 0;
      end
    end
    sclk_prev = sclk;
    if (rx_valid) begin
      chk(rx_data == ~tx_mem[rx_cnt % 16], "R5", "received byte",
          rx_data, 8'(~tx_mem[rx_cnt % 16]));
      rx_cnt++;
    end
  end

  task automatic begin_xfer(int mode, int n, bit cont);
    for (int i = 0; i < 16; i++) tx_mem[i] = 8'((i * 37 + mode * 11 + 8'h5A) & 8'hFF);
    tx_idx = 0; hs_prev = 0; tx_n = n; rx_cnt = 0; mon_cnt = 0;
    mon_bits = 0; rises = 0; seen_done = 0; cur_lanes = lanes_of(mode);
    cfg_mode = 3'(mode); cfg_bytes = 16'(n); cfg_cont = cont; go = 1'b1;
    step(1);
    go = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 6000 && !done_flag && seen_done == 0; k++) step(1);
    step(3);
  endtask

  task automatic finish_checks(int mode, int n, bit cont);
    chk(seen_done > 0, "R9", "done flag seen", seen_done, 1);
    chk(tx_idx == n, "R7", "bytes taken", tx_idx, n);
    chk(mon_cnt == n, "R7", "bytes sent", mon_cnt, n);
    chk(rx_cnt == n, "R5", "bytes received", rx_cnt, n);
    chk(rises == n * 8 / lanes_of(mode), "R7", "rising edges", rises, n * 8 / lanes_of(mode));
    chk(cs_n == !cont, cont ? "R10" : "R7", "select after end", cs_n, !cont);
    chk(sclk == 1'b0, "R6", "clock idle low", sclk, 0);
  endtask

  task automatic clear_done();
    done_clr = 1'b1; step(1); done_clr = 1'b0; step(1);
    chk(done_flag == 1'b0, "R9", "flag after clear", done_flag, 0);
  endtask

  task automatic run_xfer(int mode, int n, bit cont);
    begin_xfer(mode, n, cont);
    wait_done();
    chk(done_flag == 1'b1, "R9", "flag sticky", done_flag, 1);
    finish_checks(mode, n, cont);
    clear_done();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int r0;
    step(3);
    rst = 1'b0;
    step(1);
    // R1
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(done_flag == 1'b0, "R1", "done_flag", done_flag, 0);
    chk(tx_ready == 1'b0, "R1", "tx_ready", tx_ready, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(dout == 4'h0, "R1", "dout", dout, 0);

    // R2 R3 R4: sweep modes and byte counts
    for (int m = 0; m < 3; m++)
      for (int n = 1; n <= 5; n += 2) run_xfer(m, n, 1'b0);
    // R4: unused codes act as single lane
    run_xfer(5, 2, 1'b0);
    run_xfer(7, 1, 1'b0);

    // R8: zero byte count
    begin_xfer(1, 0, 1'b0);
    step(3);
    chk(done_flag == 1'b1, "R8", "zero count flag", done_flag, 1);
    chk(rises == 0, "R8", "zero count edges", rises, 0);
    chk(tx_idx == 0, "R8", "zero count bytes", tx_idx, 0);
    chk(cs_n == 1'b1, "R8", "zero count select", cs_n, 1);
    clear_done();

    // R6: stall while the transmit stream is empty
    begin_xfer(0, 3, 1'b0);
    stall = 1;
    step(60);
    r0 = rises;
    chk(tx_ready == 1'b1, "R6", "waiting for byte", tx_ready, 1);
    step(30);
    chk(rises == r0, "R6", "no edges while stalled", rises, r0);
    chk(sclk == 1'b0, "R6", "clock low while stalled", sclk, 0);
    stall = 0;
    wait_done();
    finish_checks(0, 3, 1'b0);
    clear_done();

    // R10: continue keeps select, next plain transaction releases it
    run_xfer(2, 2, 1'b1);
    chk(cs_n == 1'b0, "R10", "select held", cs_n, 0);
    run_xfer(1, 2, 1'b0);

    // R9: completion meets a held clear
    done_clr = 1'b1;
    begin_xfer(2, 3, 1'b0);
    wait_done();
    chk(seen_done > 0, "R9", "set wins over clear", seen_done, 1);
    chk(done_flag == 1'b0, "R9", "clear acts afterwards", done_flag, 0);
    done_clr = 1'b0;
    step(1);

    // R11: soft reset in the middle of a byte
    begin_xfer(0, 4, 1'b0);
    step(50);
    chk(cs_n == 1'b0, "R11", "select low before abort", cs_n, 0);
    soft_rst = 1'b1; step(1); soft_rst = 1'b0;
    chk(cs_n == 1'b1, "R11", "select after abort", cs_n, 1);
    chk(sclk == 1'b0, "R11", "clock after abort", sclk, 0);
    chk(tx_ready == 1'b0, "R11", "idle after abort", tx_ready, 0);
    r0 = rises;
    step(40);
    chk(rises == r0, "R11", "no edges after abort", rises, r0);
    chk(done_flag == 1'b0, "R11", "abort sets no flag", done_flag, 0);
    run_xfer(1, 3, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule